// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes a received frame, presented one byte per cycle with its total length on the first byte, and stores it in system memory through a ring of 8-byte buffer descriptors. The first word of a descriptor holds a word-aligned buffer address in its upper bits, a ring-end (wrap) flag in bit 1 and an ownership flag in bit 0 (1 = software holds the buffer). The second word is written back by the block with status and length. Each buffer takes at most 128 bytes of the frame, so a long frame spreads across several descriptors.

For every buffer the block fetches the descriptor, packs the frame bytes into little-endian 32-bit words and writes them to the buffer, writes the status word, and then sets the ownership bit to hand the buffer to software. A frame is admitted only when receive is enabled and its length passes the size rules; rejected frames are consumed from the stream with no memory traffic. Two sticky status bits and two one-cycle event pulses report completed frames and missing buffers. Memory is reached through a single valid/ready request port with a separate read-data return, and the byte stream is held off while a request is outstanding.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset the descriptor pointer is 0, the status bits are 00, no memory request is raised and no event pulses.
- R2: A pulse on base_wr loads both the ring base and the descriptor pointer with base_val; desc_ptr shows the new value the next cycle.
- R3: A frame whose length (given on its first byte, s_first=1) is below 6 or above 10240, above 1536 with jumbo_en=0, or above 1518 with big_en=0 is rejected: exactly that many bytes are consumed, no memory write occurs, no event fires and the pointer does not move.
- R4: While rx_en=0 at the first byte, the frame is consumed and dropped in the same way.
- R5: When a fetched descriptor has bit 0 set, the block sets rstat bit 1, pulses ev_no_buf, leaves the pointer on that descriptor and consumes the rest of the frame with no further writes.
- R6: Each buffer receives at most 128 frame bytes, packed little-endian (byte n of the buffer in bits 8*(n mod 4) of word n/4) at the address formed by word 0 with bits 1:0 cleared; unused lanes of a final partial word are zero.
- R7: The status word written at pointer+4 has bit 14 set only for the first buffer of a frame, and bit 15 plus the total frame length in bits 13:0 only for the last buffer; all other bits are zero.
- R8: For each buffer the status word is written before word 0 is rewritten, and word 0 is rewritten with bit 0 set and its other bits unchanged.
- R9: After a buffer, the pointer returns to the ring base if the descriptor's bit 1 was set or its offset from the base equals RING_SPAN; otherwise it advances by 8.
- R10: After the last buffer of a frame is handed over, rstat bit 0 is set and ev_rx_done pulses for one cycle.
- R11: A memory request holds its address, direction and data until m_ready, and s_ready is low in every cycle that m_valid is high.
- R12: Writing 1 to a bit of rstat_clr clears the matching rstat bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receive enable, sampled at each frame's first byte |
| big_en | input | 1 | Allows frames up to 1536 bytes |
| jumbo_en | input | 1 | Allows frames above 1536 bytes |
| base_wr | input | 1 | Load ring base and pointer |
| base_val | input | ADDR_W | Ring base value |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte accepted |
| s_first | input | 1 | Marks the first byte of a frame |
| s_len | input | LEN_W | Frame length, valid with s_first |
| s_data | input | 8 | Frame byte |
| m_valid | output | 1 | Memory request valid |
| m_ready | input | 1 | Memory request accepted |
| m_we | output | 1 | 1 = write, 0 = read |
| m_addr | output | ADDR_W | Byte address of the word |
| m_wdata | output | 32 | Write data |
| m_rvalid | input | 1 | Read data valid, at least one cycle after acceptance |
| m_rdata | input | 32 | Read data |
| ev_rx_done | output | 1 | Frame stored pulse |
| ev_no_buf | output | 1 | Buffer not available pulse |
| rstat | output | 2 | Sticky status: bit 0 frame stored, bit 1 no buffer |
| rstat_clr | input | 2 | Write-1-to-clear for rstat |
| desc_ptr | output | ADDR_W | Current descriptor pointer |

## Verification
The hardest situation to reach is running out of descriptors in the middle of a frame, after some buffers have already been filled and handed over, together with the ring returning to its base on the span limit rather than on a wrap flag. The bench reaches it by running the pointer round a shortened ring (RING_SPAN overridden to 128, 17 descriptors) with random frame lengths, then sending a frame longer than the whole ring so the pointer wraps onto a descriptor it has just handed to software, plus a directed frame that meets a pre-owned descriptor after its first buffer. A memory model with random acceptance delays exposes request holding and stream stalls.

// File: rtl/rxw_pkg.sv
// Shared definitions for the receive descriptor ring writer.
package rxw_pkg;
    // Controller states of the ring writer.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_DESC,
        ST_WAIT_RD,
        ST_FILL,
        ST_WR_DATA,
        ST_WR_STAT,
        ST_WR_OWN,
        ST_DROP
    } rxw_state_e;

    // Bit positions inside the sticky status vector.
    localparam int RSTAT_DONE  = 0;
    localparam int RSTAT_NOBUF = 1;

    // Bit positions inside the descriptor status word.
    localparam int STAT_FIRST_BIT = 14;
    localparam int STAT_LAST_BIT  = 15;

    // Bit positions inside descriptor word 0.
    localparam int DESC_OWN_BIT  = 0;
    localparam int DESC_WRAP_BIT = 1;
endpackage

// File: rtl/rxw_admit.sv
// Frame admission check.
// Decides from the announced length and the mode bits whether a frame
// may be stored. Purely combinational; assumes len is stable while used.
module rxw_admit #(
    parameter int MIN_LEN = 6,
    parameter int MAX_LEN = 10240,
    parameter int STD_MAX = 1518,
    parameter int BIG_MAX = 1536,
    parameter int LEN_W   = 14
) (
    input  logic [LEN_W-1:0] len,
    input  logic             rx_en,
    input  logic             big_en,
    input  logic             jumbo_en,
    output logic             ok
);
    localparam logic [LEN_W-1:0] MIN_V = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] MAX_V = LEN_W'(MAX_LEN);
    localparam logic [LEN_W-1:0] STD_V = LEN_W'(STD_MAX);
    localparam logic [LEN_W-1:0] BIG_V = LEN_W'(BIG_MAX);

    logic out_of_range;
    logic needs_jumbo;
    logic needs_big;

    // Classify the length against each limit.
    always_comb begin
        out_of_range = (len < MIN_V) || (len > MAX_V);
        needs_jumbo  = (len > BIG_V) && !jumbo_en;
        needs_big    = (len > STD_V) && !big_en;
        ok           = rx_en && !out_of_range && !needs_jumbo && !needs_big;
    end
endmodule

// File: rtl/rxw_packer.sv
// Byte-to-word packer for one buffer segment.
// Collects bytes little-endian into a 32-bit word and counts the bytes of
// the current segment. Assumes SEG_BYTES is a power of two of at least 4,
// and that push and word_sent never occur in the same cycle.
module rxw_packer #(
    parameter int SEG_BYTES = 128,
    localparam int SEG_W    = $clog2(SEG_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seg_clr,
    input  logic             push,
    input  logic [7:0]       din,
    input  logic             word_sent,
    output logic [31:0]      word,
    output logic [SEG_W-1:0] word_off,
    output logic             word_end,
    output logic             seg_full
);
    logic [31:0]      acc_q;
    logic [SEG_W-1:0] cnt_q;
    logic [1:0]       lane;

    // Decode the lane and the segment position of the next byte.
    always_comb begin
        lane     = cnt_q[1:0];
        word_end = (lane == 2'd3);
        seg_full = (cnt_q == SEG_W'(SEG_BYTES - 1));
        word_off = {cnt_q[SEG_W-1:2], 2'b00};
        word     = acc_q;
    end

    // Accumulate bytes and count them within the segment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (seg_clr) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (push) begin
            acc_q[8*lane +: 8] <= din;
            cnt_q              <= cnt_q + SEG_W'(1);
        end else if (word_sent) begin
            acc_q <= '0;
        end
    end
endmodule

// File: rtl/rxw_ring_ptr.sv
// Descriptor ring pointer.
// Holds the ring base and the current descriptor address. A load sets both;
// an advance returns to the base on the wrap flag or at the span limit,
// else steps to the next 8-byte descriptor.
module rxw_ring_ptr #(
    parameter int ADDR_W    = 32,
    parameter int RING_SPAN = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              adv,
    input  logic              wrap,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [ADDR_W-1:0] SPAN_V = ADDR_W'(RING_SPAN);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(8);

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              at_span;

    // Detect the descriptor that sits at the span limit.
    always_comb at_span = ((ptr_q - base_q) == SPAN_V);

    // Load or move the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            ptr_q  <= '0;
        end else if (load) begin
            base_q <= load_val;
            ptr_q  <= load_val;
        end else if (adv) begin
            ptr_q <= (wrap || at_span) ? base_q : ptr_q + STEP_V;
        end
    end

    assign ptr = ptr_q;

    // A load is visible on the pointer one cycle later.
    assert_base_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ptr == $past(load_val)));

    // An advance lands on the base or on the next descriptor.
    assert_ptr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load) |=> (ptr == base_q || ptr == $past(ptr) + STEP_V));
endmodule

// File: rtl/rx_ring_writer.sv
// Receive descriptor ring writer (top).
// Stores admitted frames into memory buffers named by a ring of 8-byte
// descriptors, up to SEG_BYTES per buffer, writes status, hands buffers to
// software and reports completion or lack of buffers. Assumes one memory
// request in flight, read data arriving at least one cycle after acceptance,
// LEN_W of at most 14, and that the sender supplies exactly s_len bytes.
module rx_ring_writer
    import rxw_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SEG_BYTES = 128,
    parameter int RING_SPAN = 8192,
    parameter int MIN_LEN   = 6,
    parameter int MAX_LEN   = 10240,
    parameter int STD_MAX   = 1518,
    parameter int BIG_MAX   = 1536,
    localparam int LEN_W    = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              big_en,
    input  logic              jumbo_en,
    input  logic              base_wr,
    input  logic [ADDR_W-1:0] base_val,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic              s_first,
    input  logic [LEN_W-1:0]  s_len,
    input  logic [7:0]        s_data,
    output logic              m_valid,
    input  logic              m_ready,
    output logic              m_we,
    output logic [ADDR_W-1:0] m_addr,
    output logic [31:0]       m_wdata,
    input  logic              m_rvalid,
    input  logic [31:0]       m_rdata,
    output logic              ev_rx_done,
    output logic              ev_no_buf,
    output logic [1:0]        rstat,
    input  logic [1:0]        rstat_clr,
    output logic [ADDR_W-1:0] desc_ptr
);
    localparam int SEG_W = $clog2(SEG_BYTES);

    rxw_state_e        state_q, state_d;
    logic [LEN_W-1:0]  rem_q;
    logic [LEN_W-1:0]  len_q;
    logic              first_q;
    logic [31:0]       desc_q;
    logic [ADDR_W-1:0] waddr_q;
    logic              seg_end_q;
    logic              ev_done_q;
    logic              ev_nobuf_q;
    logic [1:0]        rstat_q;

    logic              admit_ok;
    logic              start_ok, start_drop;
    logic              seg_clr, push, word_sent, adv, take_desc;
    logic              set_done, set_nobuf;
    logic              last_byte;
    logic [31:0]       pack_word;
    logic [SEG_W-1:0]  word_off;
    logic              word_end, seg_full;
    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] buf_base;
    logic [31:0]       stat_word;

    rxw_admit #(
        .MIN_LEN (MIN_LEN),
        .MAX_LEN (MAX_LEN),
        .STD_MAX (STD_MAX),
        .BIG_MAX (BIG_MAX),
        .LEN_W   (LEN_W)
    ) u_admit (
        .len      (s_len),
        .rx_en    (rx_en),
        .big_en   (big_en),
        .jumbo_en (jumbo_en),
        .ok       (admit_ok)
    );

    rxw_packer #(
        .SEG_BYTES (SEG_BYTES)
    ) u_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .seg_clr   (seg_clr),
        .push      (push),
        .din       (s_data),
        .word_sent (word_sent),
        .word      (pack_word),
        .word_off  (word_off),
        .word_end  (word_end),
        .seg_full  (seg_full)
    );

    rxw_ring_ptr #(
        .ADDR_W    (ADDR_W),
        .RING_SPAN (RING_SPAN)
    ) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (base_wr),
        .load_val (base_val),
        .adv      (adv),
        .wrap     (desc_q[DESC_WRAP_BIT]),
        .ptr      (ptr)
    );

    // Derived datapath values for the current buffer.
    always_comb begin
        last_byte = (rem_q == LEN_W'(1));
        buf_base  = {desc_q[ADDR_W-1:2], 2'b00};
        stat_word = '0;
        stat_word[STAT_FIRST_BIT] = first_q;
        stat_word[STAT_LAST_BIT]  = (rem_q == '0);
        if (rem_q == '0) stat_word[LEN_W-1:0] = len_q;
    end

    // Stream acceptance: bytes flow only while filling or dropping.
    always_comb begin
        s_ready = (state_q == ST_FILL) || (state_q == ST_DROP) ||
                  ((state_q == ST_IDLE) && s_valid && !s_first);
    end

    // Memory request multiplexer selected by the controller state.
    always_comb begin
        m_valid = 1'b0;
        m_we    = 1'b1;
        m_addr  = '0;
        m_wdata = '0;
        unique case (state_q)
            ST_RD_DESC: begin
                m_valid = 1'b1;
                m_we    = 1'b0;
                m_addr  = ptr;
            end
            ST_WR_DATA: begin
                m_valid = 1'b1;
                m_addr  = waddr_q;
                m_wdata = pack_word;
            end
            ST_WR_STAT: begin
                m_valid = 1'b1;
                m_addr  = ptr + ADDR_W'(4);
                m_wdata = stat_word;
            end
            ST_WR_OWN: begin
                m_valid = 1'b1;
                m_addr  = ptr;
                m_wdata = desc_q | 32'h1;
            end
            default: ;
        endcase
    end

    // Controller next state and one-cycle control strobes.
    always_comb begin
        state_d    = state_q;
        start_ok   = 1'b0;
        start_drop = 1'b0;
        seg_clr    = 1'b0;
        push       = 1'b0;
        word_sent  = 1'b0;
        adv        = 1'b0;
        take_desc  = 1'b0;
        set_done   = 1'b0;
        set_nobuf  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (s_valid && s_first) begin
                    if (admit_ok) begin
                        start_ok = 1'b1;
                        state_d  = ST_RD_DESC;
                    end else begin
                        start_drop = 1'b1;
                        state_d    = ST_DROP;
                    end
                end
            end
            ST_RD_DESC: if (m_ready) state_d = ST_WAIT_RD;
            ST_WAIT_RD: begin
                if (m_rvalid) begin
                    take_desc = 1'b1;
                    if (m_rdata[DESC_OWN_BIT]) begin
                        set_nobuf = 1'b1;
                        state_d   = ST_DROP;
                    end else begin
                        seg_clr = 1'b1;
                        state_d = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                if (s_valid) begin
                    push = 1'b1;
                    if (word_end || seg_full || last_byte) state_d = ST_WR_DATA;
                end
            end
            ST_WR_DATA: begin
                if (m_ready) begin
                    word_sent = 1'b1;
                    state_d   = seg_end_q ? ST_WR_STAT : ST_FILL;
                end
            end
            ST_WR_STAT: if (m_ready) state_d = ST_WR_OWN;
            ST_WR_OWN: begin
                if (m_ready) begin
                    adv = 1'b1;
                    if (rem_q == '0) begin
                        set_done = 1'b1;
                        state_d  = ST_IDLE;
                    end else begin
                        state_d = ST_RD_DESC;
                    end
                end
            end
            ST_DROP: if (s_valid && last_byte) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Controller and per-frame registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            rem_q      <= '0;
            len_q      <= '0;
            first_q    <= 1'b0;
            desc_q     <= '0;
            waddr_q    <= '0;
            seg_end_q  <= 1'b0;
            ev_done_q  <= 1'b0;
            ev_nobuf_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            ev_done_q  <= set_done;
            ev_nobuf_q <= set_nobuf;
            if (start_ok || start_drop) begin
                rem_q <= (s_len == '0) ? LEN_W'(1) : s_len;
                len_q <= s_len;
            end else if (push || (state_q == ST_DROP && s_valid)) begin
                rem_q <= rem_q - LEN_W'(1);
            end
            if (start_ok) first_q <= 1'b1;
            else if (state_q == ST_WR_STAT && m_ready) first_q <= 1'b0;
            if (take_desc) desc_q <= m_rdata;
            if (push) begin
                waddr_q   <= buf_base + ADDR_W'(word_off);
                seg_end_q <= seg_full || last_byte;
            end
        end
    end

    // Sticky status: clear by write-one, a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) rstat_q <= '0;
        else begin
            rstat_q <= (rstat_q & ~rstat_clr) |
                       {set_nobuf, set_done};
        end
    end

    assign ev_rx_done = ev_done_q;
    assign ev_no_buf  = ev_nobuf_q;
    assign rstat      = rstat_q;
    assign desc_ptr   = ptr;

    // A request waiting for acceptance does not change.
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) &&
                                   $stable(m_we) && $stable(m_wdata)));

    // The stream is held off while memory traffic is pending.
    assert_stream_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> !s_ready);

    // The completion pulse comes with its sticky status bit.
    assert_done_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_done |-> rstat[RSTAT_DONE]);

    // The missing-buffer pulse comes with its sticky status bit.
    assert_nobuf_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_no_buf |-> rstat[RSTAT_NOBUF]);

    // A frame ends in exactly one way.
    assert_event_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_rx_done && ev_no_buf));
endmodule

// File: tb/tb_rx_ring_writer.sv
`timescale 1ns/1ps
module tb_rx_ring_writer;
    localparam int SPAN  = 128;
    localparam int NDESC = SPAN / 8 + 1;
    localparam logic [31:0] RBASE = 32'h0000_0200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0, big_en = 1'b0, jumbo_en = 1'b0;
    logic        base_wr = 1'b0;
    logic [31:0] base_val = '0;
    logic        s_valid = 1'b0, s_first = 1'b0;
    logic        s_ready;
    logic [13:0] s_len = '0;
    logic [7:0]  s_data = '0;
    logic        m_valid, m_we;
    logic        m_ready = 1'b0;
    logic [31:0] m_addr, m_wdata;
    logic        m_rvalid = 1'b0;
    logic [31:0] m_rdata = '0;
    logic        ev_rx_done, ev_no_buf;
    logic [1:0]  rstat;
    logic [1:0]  rstat_clr = '0;
    logic [31:0] desc_ptr;

    always #4 clk = ~clk;

    rx_ring_writer #(.RING_SPAN(SPAN)) dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .big_en(big_en),
        .jumbo_en(jumbo_en), .base_wr(base_wr), .base_val(base_val),
        .s_valid(s_valid), .s_ready(s_ready), .s_first(s_first),
        .s_len(s_len), .s_data(s_data), .m_valid(m_valid), .m_ready(m_ready),
        .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_rvalid(m_rvalid),
        .m_rdata(m_rdata), .ev_rx_done(ev_rx_done), .ev_no_buf(ev_no_buf),
        .rstat(rstat), .rstat_clr(rstat_clr), .desc_ptr(desc_ptr));

    logic [31:0] mem [0:4095];
    int n_checks = 0, n_fail = 0;
    int wr_cnt = 0, n_done = 0, n_nobuf = 0;
    int viol_hold = 0, viol_stall = 0, viol_order = 0;
    logic        hold_pend = 1'b0, h_we = 1'b0;
    logic [31:0] h_addr = '0, h_data = '0, last_waddr = '0;
    logic [31:0] e_ptr = '0;
    logic [31:0] d0_m [0:NDESC-1];
    logic        own_m [0:NDESC-1];
    logic        wrap_m [0:NDESC-1];
    bit          finished = 1'b0;

    // Memory model and protocol monitors.
    always @(posedge clk) begin
        m_rvalid <= 1'b0;
        if (m_valid && m_ready) begin
            if (m_we) begin
                mem[m_addr[13:2]] = m_wdata;
                wr_cnt++;
            end else begin
                m_rdata  <= mem[m_addr[13:2]];
                m_rvalid <= 1'b1;
            end
        end
        if (rst_n) begin
            if (hold_pend && (!m_valid || m_addr != h_addr || m_we != h_we ||
                              m_wdata != h_data)) viol_hold++;
            hold_pend = m_valid && !m_ready;
            h_addr = m_addr; h_we = m_we; h_data = m_wdata;
            if (m_valid && s_ready) viol_stall++;
            if (m_valid && m_ready && m_we) begin
                if (m_addr >= RBASE && m_addr <= RBASE + SPAN && m_addr[2:0] == 3'd0 &&
                    last_waddr != m_addr + 32'd4) viol_order++;
                last_waddr = m_addr;
            end
            if (ev_rx_done) n_done++;
            if (ev_no_buf) n_nobuf++;
        end
    end

    // Random memory acceptance, changed away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            m_ready = ($urandom % 10) < 7;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] fbyte(input int k, input int tag);
        logic [31:0] h;
        h = (k * 32'h9E37_79B1) ^ tag;
        return h[7:0] ^ h[15:8] ^ h[23:16];
    endfunction

    function automatic logic [31:0] bufaddr(input int i);
        return 32'h0000_1000 + i * 128;
    endfunction

    task automatic prep_ring(input int wrap_idx, input int own_idx);
        for (int i = 0; i < NDESC; i++) begin
            d0_m[i]   = bufaddr(i) | ((i == wrap_idx) ? 32'h2 : 32'h0) |
                        ((i == own_idx) ? 32'h1 : 32'h0);
            own_m[i]  = (i == own_idx);
            wrap_m[i] = (i == wrap_idx);
            mem[(RBASE + 8 * i) >> 2]     = d0_m[i];
            mem[(RBASE + 8 * i + 4) >> 2] = 32'hDEAD_BEEF;
        end
    endtask

    task automatic send_frame(input int len, input int tag);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            s_valid = 1'b1;
            s_first = (k == 0);
            s_len   = len[13:0];
            s_data  = fbyte(k, tag);
            #1;
            while (!s_ready) begin
                @(negedge clk);
                #1;
            end
            @(posedge clk);
        end
        @(negedge clk);
        s_valid = 1'b0;
        s_first = 1'b0;
    endtask

    // Send an admitted frame and compare memory with the ring model.
    task automatic good_frame(input int len, input string req);
        int tag, before_d, before_n, rem, k0, seg, idx, n;
        bit bna;
        logic [31:0] p, expw, expst;
        tag = $urandom;
        before_d = n_done;
        before_n = n_nobuf;
        send_frame(len, tag);
        for (int w = 0; w < 600; w++) begin
            if (n_done + n_nobuf > before_d + before_n) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
        p = e_ptr; rem = len; k0 = 0; seg = 0; bna = 1'b0;
        while (rem > 0) begin
            idx = (p - RBASE) / 8;
            if (own_m[idx]) begin
                bna = 1'b1;
                break;
            end
            n = (rem < 128) ? rem : 128;
            for (int w = 0; w < (n + 3) / 4; w++) begin
                expw = '0;
                for (int b = 0; b < 4; b++)
                    if (4 * w + b < n) expw[8 * b +: 8] = fbyte(k0 + 4 * w + b, tag);
                chk(mem[(bufaddr(idx) >> 2) + w] == expw, "R6 buffer data",
                    mem[(bufaddr(idx) >> 2) + w], expw);
            end
            rem -= n;
            k0 += n;
            expst = (seg == 0) ? 32'h4000 : 32'h0;
            if (rem == 0) expst = expst | 32'h8000 | len;
            chk(mem[(p + 4) >> 2] == expst, "R7 status word", mem[(p + 4) >> 2], expst);
            chk(mem[p >> 2] == (d0_m[idx] | 32'h1), "R8 ownership handover",
                mem[p >> 2], d0_m[idx] | 32'h1);
            own_m[idx] = 1'b1;
            seg++;
            p = (wrap_m[idx] || (p - RBASE) == SPAN) ? RBASE : p + 8;
        end
        e_ptr = p;
        chk(desc_ptr == p, {req, " R9 pointer"}, desc_ptr, p);
        if (bna) begin
            chk(n_nobuf == before_n + 1 && n_done == before_d, "R5 no-buffer event",
                n_nobuf - before_n, 1);
            chk(rstat[1] == 1'b1, "R5 status bit", rstat, 2);
        end else begin
            chk(n_done == before_d + 1 && n_nobuf == before_n, "R10 done event",
                n_done - before_d, 1);
            chk(rstat[0] == 1'b1, "R10 status bit", rstat, 1);
        end
    endtask

    // Send a frame that must be dropped with no trace.
    task automatic drop_frame(input int len, input string req);
        int w0, d0, nb0;
        w0 = wr_cnt; d0 = n_done; nb0 = n_nobuf;
        send_frame(len, 7);
        repeat (10) @(negedge clk);
        chk(wr_cnt == w0, {req, " no writes"}, wr_cnt - w0, 0);
        chk(n_done == d0 && n_nobuf == nb0, {req, " no events"}, n_done - d0, 0);
        chk(desc_ptr == e_ptr, {req, " pointer kept"}, desc_ptr, e_ptr);
    endtask

    function automatic int cur_idx();
        return (e_ptr - RBASE) / 8;
    endfunction

    initial begin
        repeat (5) @(posedge clk);
        #1;
        // R1: reset state.
        chk(desc_ptr == 0, "R1 pointer", desc_ptr, 0);
        chk(rstat == 2'b00, "R1 status", rstat, 0);
        chk(!m_valid && !ev_rx_done && !ev_no_buf, "R1 idle outputs", m_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        base_val = RBASE;
        base_wr  = 1'b1;
        @(negedge clk);
        base_wr = 1'b0;
        e_ptr   = RBASE;
        chk(desc_ptr == RBASE, "R2 base load", desc_ptr, RBASE);
        rx_en = 1'b1;

        // Directed sizes around word and buffer boundaries.
        prep_ring(-1, -1); good_frame(6, "R6 min");
        prep_ring(-1, -1); good_frame(128, "R6 one full buffer");
        prep_ring(-1, -1); good_frame(129, "R6 one spare byte");
        prep_ring(-1, -1); good_frame(300, "R7 three buffers");
        // R9: wrap flag on the next descriptor.
        prep_ring((cur_idx() + 1) % NDESC, -1); good_frame(300, "R9 wrap flag");
        chk(desc_ptr == RBASE + 8, "R9 wrap returns to base", desc_ptr, RBASE + 8);

        // Random frames run the pointer round the span limit.
        for (int f = 0; f < 14; f++) begin
            int len, wi;
            len = 6 + ($urandom % 700);
            wi  = (($urandom % 3) == 0) ? int'($urandom % NDESC) : -1;
            prep_ring(wi, -1);
            good_frame(len, "R9 random");
        end

        // R3: size rules.
        drop_frame(5, "R3 too short");
        drop_frame(1519, "R3 big off");
        big_en = 1'b1;
        prep_ring(-1, -1); good_frame(1519, "R3 big on");
        drop_frame(1537, "R3 jumbo off");
        jumbo_en = 1'b1;
        prep_ring(-1, -1); good_frame(1600, "R3 jumbo on");
        drop_frame(10241, "R3 over maximum");
        big_en = 1'b0;
        drop_frame(1519, "R3 jumbo without big");
        big_en = 1'b1;

        // R5: a pre-owned descriptor after the first buffer.
        prep_ring(-1, (cur_idx() + 1) % NDESC); good_frame(200, "R5 owned descriptor");
        // R5: a frame longer than the whole ring meets its own handed-over buffer.
        prep_ring(-1, -1); good_frame(2500, "R5 ring exhausted");

        // R4: receive disabled.
        rx_en = 1'b0;
        drop_frame(60, "R4 receive off");
        rx_en = 1'b1;
        prep_ring(-1, -1); good_frame(64, "R4 receive back on");

        // R12: write-one-to-clear.
        chk(rstat == 2'b11, "R12 both set", rstat, 3);
        @(negedge clk); rstat_clr = 2'b01;
        @(negedge clk); rstat_clr = 2'b00;
        chk(rstat == 2'b10, "R12 clear bit 0", rstat, 2);
        @(negedge clk); rstat_clr = 2'b10;
        @(negedge clk); rstat_clr = 2'b00;
        chk(rstat == 2'b00, "R12 clear bit 1", rstat, 0);

        // R11 and R8: protocol monitors.
        chk(viol_hold == 0, "R11 request held", viol_hold, 0);
        chk(viol_stall == 0, "R11 stream stalled", viol_stall, 0);
        chk(viol_order == 0, "R8 status before ownership", viol_order, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        int seed_v;
        seed_v = $urandom(32'd1357);
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule